// File: doc/BRIEF.md
# Debug Address Watchpoint Generator

This block watches the addresses of retiring instructions and of data accesses and raises a pulse on a six-bit watchpoint vector whenever one of its address comparators sees a match. Four comparators look at instruction addresses and two look at data addresses. Each comparator owns exactly one bit of the output. Debug logic elsewhere in the chip, or external trace equipment, can use the pulses without taking an exception or stopping the core.

A register-write port loads the compare address for one comparator at a time. For the data comparators, the same write also loads the access kinds that count as a hit: reads, writes, or both. Watchpoints have no enable bits of their own. A comparator fires whenever its condition is met, as long as either the internal or the external debug mode is selected. All pulses are held off while a debug session is active.

Top module: `dbg_addr_watch`

## Requirements
- R1: On synchronous reset, `wp_o` goes to zero, every compare address becomes 0, and both data comparators have neither reads nor writes selected, so they cannot fire until they are written.
- R2: An instruction comparator matches when `i_valid` is high and `i_addr` equals its compare address with the two lowest bits of both ignored. When `i_valid` is low, bits 3..0 stay low.
- R3: A data comparator matches when `d_valid` is high and `d_addr` equals its compare address in every bit. It fires on a read (`d_is_write`=0) only if its read select is set, and on a write (`d_is_write`=1) only if its write select is set. With neither select set, it never fires.
- R4: Each watchpoint bit is registered. It is high in the cycle after a matching access and only for that one cycle, unless the matching access is repeated.
- R5: No watchpoint asserts unless `mode_int` or `mode_ext` is high. Either one of them alone is enough.
- R6: While `session_active` is high, all of `wp_o` is low in the following cycle.
- R7: A write to a comparator applies from the next cycle onward. An access in the same cycle as the write is compared against the old value.
- R8: Several watchpoint bits, from instruction and data comparators alike, can be high in the same cycle.
- R9: `cw_idx` 0..3 selects instruction comparators 0..3, which drive `wp_o[0]`..`wp_o[3]`. Values 4 and 5 select data comparators 0 and 1, which drive `wp_o[4]` and `wp_o[5]`. Writes with `cw_idx` 6 or 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Retiring instruction address is valid |
| i_addr | input | 32 | Retiring instruction address |
| d_valid | input | 1 | Data access is valid |
| d_addr | input | 32 | Data access byte address |
| d_is_write | input | 1 | 1 for a write access, 0 for a read access |
| cw_en | input | 1 | Comparator register write strobe |
| cw_idx | input | 3 | Comparator index to write |
| cw_addr | input | 32 | New compare address |
| cw_on_rd | input | 1 | Data comparator fires on reads |
| cw_on_wr | input | 1 | Data comparator fires on writes |
| mode_int | input | 1 | Internal debug mode selected |
| mode_ext | input | 1 | External debug mode selected |
| session_active | input | 1 | Debug session in progress; blocks watchpoints |
| wp_o | output | 6 | Watchpoint pulses, one per comparator |

## Verification
Two kinds of event can fall in the same cycle. The first is a comparator write together with an access to the newly written address. The bench issues both in one cycle and expects no pulse from the old value, then expects a pulse when the same access is repeated one cycle later. The second is an instruction hit together with a data hit. The bench points two instruction comparators and one data comparator at a single address and drives a fetch and a read of it together, and it expects exactly those three bits in the one output word.

// File: rtl/dbg_wp_pkg.sv
package dbg_wp_pkg;

    localparam int ADDR_W   = 32;
    localparam int N_IAC    = 4;
    localparam int N_DAC    = 2;
    localparam int N_WP     = N_IAC + N_DAC;
    localparam int IDX_W    = $clog2(N_WP + 1);
    localparam int IGN_BITS = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        addr_t addr;
        logic  on_rd;
        logic  on_wr;
    } dac_cfg_t;

    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  is_write;
    } dacc_t;

    function automatic logic word_match(addr_t a, addr_t b);
        addr_t mask;
        mask = ~addr_t'((1 << IGN_BITS) - 1);
        return (a & mask) == (b & mask);
    endfunction

endpackage

// File: rtl/dbg_wp_cfg_regs.sv
module dbg_wp_cfg_regs
    import dbg_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  addr_t             cw_addr,
    input  logic              cw_on_rd,
    input  logic              cw_on_wr,
    output addr_t             iac_cmp [N_IAC],
    output dac_cfg_t          dac_cfg [N_DAC]
);

    for (genvar g = 0; g < N_IAC; g++) begin : g_iac
        always_ff @(posedge clk) begin
            if (rst)
                iac_cmp[g] <= '0;
            else if (cw_en && cw_idx == IDX_W'(g))
                iac_cmp[g] <= cw_addr;
        end
    end

    for (genvar g = 0; g < N_DAC; g++) begin : g_dac
        always_ff @(posedge clk) begin
            if (rst)
                dac_cfg[g] <= '0;
            else if (cw_en && cw_idx == IDX_W'(N_IAC + g))
                dac_cfg[g] <= '{addr: cw_addr, on_rd: cw_on_rd, on_wr: cw_on_wr};
        end
    end

endmodule

// File: rtl/dbg_wp_iac.sv
module dbg_wp_iac
    import dbg_wp_pkg::*;
(
    input  logic  valid,
    input  addr_t addr,
    input  addr_t cmp,
    output logic  hit
);

    always_comb hit = valid && word_match(addr, cmp);

endmodule

// File: rtl/dbg_wp_dac.sv
module dbg_wp_dac
    import dbg_wp_pkg::*;
(
    input  dacc_t    acc,
    input  dac_cfg_t cfg,
    output logic     hit
);

    logic kind_ok;

    always_comb begin
        kind_ok = acc.is_write ? cfg.on_wr : cfg.on_rd;
        hit     = acc.valid && kind_ok && (acc.addr == cfg.addr);
    end

endmodule

// File: rtl/dbg_addr_watch.sv
module dbg_addr_watch
    import dbg_wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [ADDR_W-1:0] i_addr,
    input  logic              d_valid,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic              d_is_write,
    input  logic              cw_en,
    input  logic [IDX_W-1:0]  cw_idx,
    input  logic [ADDR_W-1:0] cw_addr,
    input  logic              cw_on_rd,
    input  logic              cw_on_wr,
    input  logic              mode_int,
    input  logic              mode_ext,
    input  logic              session_active,
    output logic [N_WP-1:0]   wp_o
);

    addr_t           iac_cmp [N_IAC];
    dac_cfg_t        dac_cfg [N_DAC];
    logic [N_WP-1:0] hits;
    logic            gate_open;
    dacc_t           dacc;

    dbg_wp_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cw_en    (cw_en),
        .cw_idx   (cw_idx),
        .cw_addr  (cw_addr),
        .cw_on_rd (cw_on_rd),
        .cw_on_wr (cw_on_wr),
        .iac_cmp  (iac_cmp),
        .dac_cfg  (dac_cfg)
    );

    always_comb dacc = '{valid: d_valid, addr: d_addr, is_write: d_is_write};

    for (genvar g = 0; g < N_IAC; g++) begin : g_icmp
        dbg_wp_iac u_iac (
            .valid (i_valid),
            .addr  (i_addr),
            .cmp   (iac_cmp[g]),
            .hit   (hits[g])
        );
    end

    for (genvar g = 0; g < N_DAC; g++) begin : g_dcmp
        dbg_wp_dac u_dac (
            .acc (dacc),
            .cfg (dac_cfg[g]),
            .hit (hits[N_IAC + g])
        );
    end

    // Debug mode must be selected and no session in progress.
    always_comb gate_open = (mode_int || mode_ext) && !session_active;

    always_ff @(posedge clk) begin
        if (rst)
            wp_o <= '0;
        else
            wp_o <= gate_open ? hits : '0;
    end

    a_r6_session_blocks: assert property (@(posedge clk) disable iff (rst)
        session_active |=> wp_o == '0);

    a_r5_mode_required: assert property (@(posedge clk) disable iff (rst)
        !(mode_int || mode_ext) |=> wp_o == '0);

    a_r2_ifetch_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> wp_o[N_IAC-1:0] == '0);

    a_r3_data_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> wp_o[N_WP-1:N_IAC] == '0);

    a_r4_pulse_needs_access: assert property (@(posedge clk) disable iff (rst)
        !(i_valid || d_valid) |=> wp_o == '0);

endmodule

// File: tb/sim_dbg_addr_watch.sv
`timescale 1ns/1ps
module sim_dbg_addr_watch;

    logic        clk = 1'b0;
    logic        rst;
    logic        i_valid, d_valid, d_is_write;
    logic [31:0] i_addr, d_addr, cw_addr;
    logic        cw_en, cw_on_rd, cw_on_wr;
    logic [2:0]  cw_idx;
    logic        mode_int, mode_ext, session_active;
    logic [5:0]  wp_o;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    dbg_addr_watch u0 (
        .clk(clk), .rst(rst),
        .i_valid(i_valid), .i_addr(i_addr),
        .d_valid(d_valid), .d_addr(d_addr), .d_is_write(d_is_write),
        .cw_en(cw_en), .cw_idx(cw_idx), .cw_addr(cw_addr),
        .cw_on_rd(cw_on_rd), .cw_on_wr(cw_on_wr),
        .mode_int(mode_int), .mode_ext(mode_ext),
        .session_active(session_active),
        .wp_o(wp_o)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
        $finish;
    end

    // Inputs are changed just after a falling edge; one rising edge later
    // the registered output is sampled at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [5:0] exp);
        vectors++;
        if (wp_o !== exp) begin
            misses++;
            $display("FAIL %s: actual=%b expected=%b", req, wp_o, exp);
        end
    endtask

    task automatic idle();
        i_valid = 0; d_valid = 0; cw_en = 0; d_is_write = 0;
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [31:0] a,
                       input logic rd, input logic wr);
        idle();
        cw_en = 1; cw_idx = idx; cw_addr = a; cw_on_rd = rd; cw_on_wr = wr;
        tick();
        cw_en = 0;
    endtask

    task automatic fetch(input logic [31:0] a, string req, input logic [5:0] exp);
        idle(); i_valid = 1; i_addr = a;
        tick(); check(req, exp);
        idle();
    endtask

    task automatic dacc(input logic [31:0] a, input logic wr, string req,
                        input logic [5:0] exp);
        idle(); d_valid = 1; d_addr = a; d_is_write = wr;
        tick(); check(req, exp);
        idle();
    endtask

    task automatic t_reset();
        rst = 1; idle(); cw_idx = 0; cw_addr = 0; cw_on_rd = 0; cw_on_wr = 0;
        i_addr = 0; d_addr = 0; mode_int = 1; mode_ext = 0; session_active = 0;
        i_valid = 1; i_addr = 32'h0;
        repeat (3) tick();
        check("R1 reset output", 6'b0);
        rst = 0;
        idle();
        tick();
        check("R1 idle after reset", 6'b0);
        // All compare addresses are 0 after reset.
        fetch(32'h0000_0002, "R1 fetch at zero hits every iac", 6'b001111);
        dacc(32'h0, 0, "R1 data read, no kind selected", 6'b0);
        dacc(32'h0, 1, "R1 data write, no kind selected", 6'b0);
    endtask

    task automatic t_iac();
        for (int k = 0; k < 4; k++) cfg(3'(k), 32'hF000_0000 + 32'(k) * 32'h10, 0, 0);
        cfg(3'd1, 32'h1000_0104, 0, 0);
        fetch(32'h1000_0107, "R2 low bits ignored", 6'b000010);
        fetch(32'h1000_0104, "R2 exact word", 6'b000010);
        fetch(32'h1000_0108, "R2 next word misses", 6'b0);
        idle(); i_addr = 32'h1000_0104; tick();
        check("R2 no hit without i_valid", 6'b0);
        fetch(32'hF000_0030, "R9 iac3 drives bit 3", 6'b001000);
    endtask

    task automatic t_dac();
        cfg(3'd4, 32'h2000_0010, 1, 0);
        cfg(3'd5, 32'h2000_0010, 0, 1);
        dacc(32'h2000_0010, 0, "R3 read hits read-select dac0", 6'b010000);
        dacc(32'h2000_0010, 1, "R3 write hits write-select dac1", 6'b100000);
        dacc(32'h2000_0011, 0, "R3 byte address must be exact", 6'b0);
        cfg(3'd5, 32'h2000_0010, 1, 1);
        dacc(32'h2000_0010, 0, "R3 both kinds, read", 6'b110000);
        dacc(32'h2000_0010, 1, "R3 both kinds, write", 6'b100000);
        cfg(3'd4, 32'h2000_0010, 0, 0);
        dacc(32'h2000_0010, 0, "R3 neither kind never fires", 6'b100000);
        cfg(3'd6, 32'h3000_0000, 1, 1);
        dacc(32'h2000_0010, 1, "R9 index 6 write changes nothing", 6'b100000);
        dacc(32'h3000_0000, 1, "R9 index 6 loads no comparator", 6'b0);
    endtask

    task automatic t_pulse();
        idle(); i_valid = 1; i_addr = 32'h1000_0104;
        tick(); check("R4 first cycle", 6'b000010);
        tick(); check("R4 repeated access", 6'b000010);
        idle(); tick(); check("R4 pulse ends", 6'b0);
    endtask

    task automatic t_mode();
        mode_int = 0; mode_ext = 0;
        fetch(32'h1000_0104, "R5 no mode blocks", 6'b0);
        mode_ext = 1;
        fetch(32'h1000_0104, "R5 external mode alone", 6'b000010);
        mode_ext = 0; mode_int = 1;
        fetch(32'h1000_0104, "R5 internal mode alone", 6'b000010);
    endtask

    task automatic t_session();
        session_active = 1;
        fetch(32'h1000_0104, "R6 session blocks iac", 6'b0);
        dacc(32'h2000_0010, 1, "R6 session blocks dac", 6'b0);
        session_active = 0;
        fetch(32'h1000_0104, "R6 session over", 6'b000010);
    endtask

    task automatic t_timing();
        idle();
        cw_en = 1; cw_idx = 3'd2; cw_addr = 32'h4000_0040;
        cw_on_rd = 0; cw_on_wr = 0;
        i_valid = 1; i_addr = 32'h4000_0040;
        tick(); check("R7 same-cycle write uses old value", 6'b0);
        cw_en = 0;
        tick(); check("R7 new value next cycle", 6'b000100);
        idle();
    endtask

    task automatic t_multi();
        cfg(3'd0, 32'h5000_0000, 0, 0);
        cfg(3'd3, 32'h5000_0000, 0, 0);
        cfg(3'd4, 32'h5000_0000, 1, 0);
        idle();
        i_valid = 1; i_addr = 32'h5000_0000;
        d_valid = 1; d_addr = 32'h5000_0000; d_is_write = 0;
        tick(); check("R8 three bits together", 6'b011001);
        idle(); tick(); check("R8 all clear after", 6'b0);
    endtask

    initial begin
        t_reset();
        t_iac();
        t_dac();
        t_pulse();
        t_mode();
        t_session();
        t_timing();
        t_multi();
        summary();
        $finish;
    end

endmodule